// File: doc/BRIEF.md
# CAN Error and Overload Frame Sequencer

This block drives a CAN node's transmit line while the node signals an error or an overload, and it times the interframe intermission that follows. Every state change happens on a one-cycle bit-time strobe. The strobe comes from the bit timing logic, which sits outside this block. On each strobe the block reads the sampled bus level, an error-detected pulse, the node's error-passive status and an end-of-frame pulse. An internal request for extra delay may arrive on any clock cycle and is held until it can be served.

When an error is reported, the block sends an error flag. An error-active node sends dominant bits. An error-passive node sends recessive bits and waits for a run of equal bus samples. The flag is followed by an eight-bit recessive delimiter and a three-bit intermission, after which a ready pulse returns control to normal frame processing. An overload flag is sent in three cases: after an internal request, after a dominant sample early in the intermission, or after a dominant sample on the last delimiter bit. The block also raises a pulse that discards the frame being received and a pulse that asks for an error-counter increment.

Top module: `can_eo_seq`

## Requirements
- R1: After reset, tx_bit_o is 1 (recessive) and discard_o, err_inc_o and ready_o are 0.
- R2: When err_det_i is high on a strobe in the idle, delimiter or intermission phase and err_passive_i is 0, tx_bit_o is 0 (dominant) for exactly the next six bit times.
- R3: When err_passive_i is 1 at that strobe, tx_bit_o stays 1 and the flag phase ends only on the strobe that completes six consecutive equal rx_bit_i samples taken during the flag.
- R4: Starting an error flag pulses err_inc_o for one cycle. discard_o pulses with it only when the error is detected in the idle phase, where a frame is being received.
- R5: After any flag, tx_bit_o is 1 and the block waits for a strobe with rx_bit_i=1. That strobe is delimiter bit 1, and the delimiter ends after bit 8.
- R6: During any flag phase, rx_bit_i=0 and err_det_i have no effect, and superposed dominant bits only lengthen the wait for a recessive level.
- R7: A pulse on ovl_req_i is held. The next time the intermission would start (frame_end_i on a strobe in idle, or the end of a delimiter), an overload flag of six dominant bits takes the place of the first intermission bit. A request made mid-intermission never starts a flag within that intermission.
- R8: rx_bit_i=0 at intermission bit 1 or 2 starts an overload flag of six dominant bits from the next bit time, with no err_inc_o pulse.
- R9: rx_bit_i=0 at delimiter bit 8 starts an overload flag from the next bit time, with no err_inc_o pulse.
- R10: The intermission lasts three bit times. ready_o pulses for one cycle after its third strobe, and rx_bit_i=0 at bit 3 does not start an overload.
- R11: Dominant is encoded as 0. Nothing advances and no output pulse occurs without bit_stb_i, and each pulse appears in the clock cycle after the strobe edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_stb_i | input | 1 | One-cycle pulse per bit time |
| rx_bit_i | input | 1 | Sampled bus level, 0 = dominant |
| err_det_i | input | 1 | Error detected, read on a strobe |
| err_passive_i | input | 1 | Node is error-passive |
| ovl_req_i | input | 1 | Internal request for extra delay |
| frame_end_i | input | 1 | Frame finished, intermission starts, read on a strobe |
| tx_bit_o | output | 1 | Transmit bit, 0 = dominant |
| discard_o | output | 1 | Pulse: drop the frame being received |
| err_inc_o | output | 1 | Pulse: request an error-counter increment |
| ready_o | output | 1 | Pulse: intermission over, normal processing resumes |

## Verification
The embedded assertions check, on every cycle, that:
- an active error flag is dominant and a passive one is recessive;
- no run of dominant transmit bits is longer than the flag length;
- a discard always comes with an increment request;
- no overload start requests an increment;
- ready only follows a strobe, with the line recessive.

Whether the delimiter ends exactly on bit 8, whether the passive flag waits for the right run of samples, and whether a held overload request lands on the first bit of the next intermission are sequence properties. Only the bench's scenarios show these, by comparing each cycle against its behavioural model.

// File: rtl/can_eo_pkg.sv
package can_eo_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_EFLAG,
    ST_PFLAG,
    ST_OFLAG,
    ST_DWAIT,
    ST_DELIM,
    ST_INTER
  } eo_state_e;
endpackage

// File: rtl/can_eo_bit_cnt.sv
module can_eo_bit_cnt #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_o <= '0;
    else if (clr_i) cnt_o <= '0;
    else if (inc_i) cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/can_eo_run_det.sv
// Counts consecutive equal bus samples while enabled; hit on the completing sample.
module can_eo_run_det #(
  parameter int RUN_BITS = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic stb_i,
  input  logic bit_i,
  output logic hit_o
);
  localparam int RW = $clog2(RUN_BITS + 1);
  localparam logic [RW-1:0] RUN_LAST = RW'(RUN_BITS - 1);

  logic [RW-1:0] run_q;
  logic          last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= '0;
      last_q <= 1'b1;
    end else if (!en_i) begin
      run_q  <= '0;
    end else if (stb_i) begin
      run_q  <= (run_q != '0 && bit_i == last_q) ? run_q + 1'b1 : RW'(1);
      last_q <= bit_i;
    end
  end

  assign hit_o = en_i && stb_i && (run_q == RUN_LAST) && (bit_i == last_q);
endmodule

// File: rtl/can_eo_ovl_pend.sv
module can_eo_ovl_pend (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic pend_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    pend_o <= 1'b0;
    else if (set_i) pend_o <= 1'b1;
    else if (clr_i) pend_o <= 1'b0;
  end
endmodule

// File: rtl/can_eo_seq.sv
module can_eo_seq
  import can_eo_pkg::*;
#(
  parameter int FLAG_BITS  = 6,
  parameter int DELIM_BITS = 8,
  parameter int INTER_BITS = 3,
  parameter int OVL_BITS   = 2,
  parameter int RUN_BITS   = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_stb_i,
  input  logic rx_bit_i,
  input  logic err_det_i,
  input  logic err_passive_i,
  input  logic ovl_req_i,
  input  logic frame_end_i,
  output logic tx_bit_o,
  output logic discard_o,
  output logic err_inc_o,
  output logic ready_o
);
  localparam int MAX_A = (FLAG_BITS > DELIM_BITS) ? FLAG_BITS : DELIM_BITS;
  localparam int MAX_C = (MAX_A > INTER_BITS) ? MAX_A : INTER_BITS;
  localparam int CNT_W = $clog2(MAX_C + 1);
  localparam logic [CNT_W-1:0] FLAG_LAST  = CNT_W'(FLAG_BITS - 1);
  localparam logic [CNT_W-1:0] DELIM_LAST = CNT_W'(DELIM_BITS - 2);
  localparam logic [CNT_W-1:0] INTER_LAST = CNT_W'(INTER_BITS - 1);
  localparam logic [CNT_W-1:0] OVL_WIN    = CNT_W'(OVL_BITS);

  eo_state_e        state_q, state_d;
  logic [CNT_W-1:0] cnt;
  logic             run_hit, pend, consume;
  logic             disc_d, inc_d, rdy_d;
  logic             disc_q, inc_q, rdy_q;
  logic             err_ok;

  can_eo_bit_cnt #(.W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (bit_stb_i && (state_d != state_q)),
    .inc_i  (bit_stb_i && (state_d == state_q)),
    .cnt_o  (cnt)
  );

  can_eo_run_det #(.RUN_BITS(RUN_BITS)) u_run (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (state_q == ST_PFLAG),
    .stb_i  (bit_stb_i),
    .bit_i  (rx_bit_i),
    .hit_o  (run_hit)
  );

  can_eo_ovl_pend u_pend (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (ovl_req_i),
    .clr_i  (consume),
    .pend_o (pend)
  );

  // Errors are accepted outside flag phases only; superposed flags are absorbed.
  assign err_ok = err_det_i && (state_q == ST_IDLE || state_q == ST_DWAIT ||
                                state_q == ST_DELIM || state_q == ST_INTER);

  always_comb begin
    state_d = state_q;
    disc_d  = 1'b0;
    inc_d   = 1'b0;
    rdy_d   = 1'b0;
    consume = 1'b0;
    if (bit_stb_i) begin
      if (err_ok) begin
        state_d = err_passive_i ? ST_PFLAG : ST_EFLAG;
        inc_d   = 1'b1;
        disc_d  = (state_q == ST_IDLE);
      end else begin
        unique case (state_q)
          ST_IDLE: if (frame_end_i) begin
            if (pend) begin
              state_d = ST_OFLAG;
              consume = 1'b1;
            end else begin
              state_d = ST_INTER;
            end
          end
          ST_EFLAG, ST_OFLAG: if (cnt == FLAG_LAST) state_d = ST_DWAIT;
          ST_PFLAG: if (run_hit) state_d = ST_DWAIT;
          ST_DWAIT: if (rx_bit_i) state_d = ST_DELIM;
          ST_DELIM: if (cnt == DELIM_LAST) begin
            if (!rx_bit_i) begin
              state_d = ST_OFLAG;
            end else if (pend) begin
              state_d = ST_OFLAG;
              consume = 1'b1;
            end else begin
              state_d = ST_INTER;
            end
          end
          ST_INTER: begin
            if (!rx_bit_i && cnt < OVL_WIN) begin
              state_d = ST_OFLAG;
            end else if (cnt == INTER_LAST) begin
              state_d = ST_IDLE;
              rdy_d   = 1'b1;
            end
          end
          default: state_d = ST_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      disc_q  <= 1'b0;
      inc_q   <= 1'b0;
      rdy_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      disc_q  <= disc_d;
      inc_q   <= inc_d;
      rdy_q   <= rdy_d;
    end
  end

  assign tx_bit_o  = !(state_q == ST_EFLAG || state_q == ST_OFLAG);
  assign discard_o = disc_q;
  assign err_inc_o = inc_q;
  assign ready_o   = rdy_q;

  // Checker state: length of the current dominant transmit run in bit times.
  logic [CNT_W:0] dom_run;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     dom_run <= '0;
    else if (tx_bit_o)               dom_run <= '0;
    else if (bit_stb_i)              dom_run <= dom_run + 1'b1;
  end

  assert_err_flag_dominant_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_inc_o && !$past(err_passive_i)) |-> !tx_bit_o);

  assert_flag_len_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_stb_i && !tx_bit_o) |-> (dom_run < (CNT_W+1)'(FLAG_BITS)));

  assert_passive_flag_recessive_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_inc_o && $past(err_passive_i)) |-> tx_bit_o);

  assert_discard_with_inc_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    discard_o |-> err_inc_o);

  assert_ovl_no_inc_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_OFLAG && $past(state_q) != ST_OFLAG) |-> !err_inc_o);

  assert_ready_recessive_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> tx_bit_o);

  assert_pulse_on_strobe_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o || err_inc_o) |-> $past(bit_stb_i));
endmodule

// File: tb/can_eo_seq_tb_top.sv
`timescale 1ns/1ps
module can_eo_seq_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stb = 1'b0, rx = 1'b1, err = 1'b0, pas = 1'b0, ovl = 1'b0, fe = 1'b0;
  logic tx, disc, inc, rdy;

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";

  int dom = 0, n_disc = 0, n_inc = 0, n_rdy = 0;
  logic last_tx;

  always #2.5 clk = ~clk;

  can_eo_seq dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bit_stb_i(stb), .rx_bit_i(rx),
    .err_det_i(err), .err_passive_i(pas), .ovl_req_i(ovl), .frame_end_i(fe),
    .tx_bit_o(tx), .discard_o(disc), .err_inc_o(inc), .ready_o(rdy)
  );

  // Behavioural reference: 0 idle,1 eflag,2 pflag,3 oflag,4 wait,5 delim,6 inter
  int   ph;
  int   n;
  bit   q[$];
  bit   m_pend;
  logic m_tx, m_disc, m_inc, m_rdy;

  function automatic bit six_equal();
    if (q.size() < 6) return 0;
    for (int k = q.size() - 6; k < q.size(); k++)
      if (q[k] != q[q.size()-1]) return 0;
    return 1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph = 0; n = 0; q.delete(); m_pend = 0;
      m_tx = 1; m_disc = 0; m_inc = 0; m_rdy = 0;
    end else begin
      automatic bit go_inter = 0;
      automatic bit take_err = err && (ph == 0 || ph == 4 || ph == 5 || ph == 6);
      m_disc = 0; m_inc = 0; m_rdy = 0;
      if (stb) begin
        if (take_err) begin
          m_disc = (ph == 0); m_inc = 1;
          ph = pas ? 2 : 1; n = 0; q.delete();
        end else begin
          case (ph)
            0: if (fe) go_inter = 1;
            1, 3: begin n++; if (n == 6) ph = 4; end
            2: begin q.push_back(rx); if (six_equal()) ph = 4; end
            4: if (rx) begin ph = 5; n = 1; end
            5: begin
              n++;
              if (n == 8) begin
                if (!rx) begin ph = 3; n = 0; end
                else go_inter = 1;
              end
            end
            6: begin
              n++;
              if (n <= 2 && !rx) begin ph = 3; n = 0; end
              else if (n == 3) begin ph = 0; m_rdy = 1; end
            end
            default: ;
          endcase
          if (go_inter) begin
            n = 0;
            if (m_pend) begin m_pend = 0; ph = 3; end
            else ph = 6;
          end
        end
      end
      if (ovl) m_pend = 1;
      m_tx = !(ph == 1 || ph == 3);
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk(cur_req, "model tx", tx, m_tx);
      chk(cur_req, "model discard", disc, m_disc);
      chk(cur_req, "model err_inc", inc, m_inc);
      chk(cur_req, "model ready", rdy, m_rdy);
    end
  end

  task automatic clr_cnt();
    dom = 0; n_disc = 0; n_inc = 0; n_rdy = 0;
  endtask

  task automatic bit_t(input logic b, input logic e, input logic f, input logic o);
    @(negedge clk);
    stb = 1; rx = b; err = e; fe = f; ovl = o;
    @(negedge clk);
    stb = 0; err = 0; fe = 0; ovl = 0;
    last_tx = tx;
    if (!tx) dom++;
    n_disc += disc; n_inc += inc; n_rdy += rdy;
    repeat (2) @(negedge clk);
  endtask

  task automatic bits(input int cnt, input logic b);
    for (int k = 0; k < cnt; k++) bit_t(b, 0, 0, 0);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    cur_req = "R1";
    chk("R1", "reset tx", tx, 1);
    chk("R1", "reset pulses", disc | inc | rdy, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R11: no strobe, no effect
    cur_req = "R11";
    clr_cnt();
    err = 1; fe = 1;
    for (int k = 0; k < 10; k++) begin @(negedge clk); n_inc += inc; end
    err = 0; fe = 0;
    chk("R11", "no strobe inc", n_inc, 0);
    chk("R11", "no strobe tx", tx, 1);
    bits(3, 1);
    chk("R11", "idle tx recessive", last_tx, 1);

    // R2/R4/R5/R6/R10: active error in frame, superposed flags
    cur_req = "R2";
    clr_cnt();
    bit_t(1, 1, 0, 0);
    chk("R4", "discard in frame", n_disc, 1);
    bits(2, 0);
    cur_req = "R6";
    bit_t(0, 1, 0, 0);
    bits(3, 0);
    chk("R2", "dominant flag bits", dom, 6);
    chk("R6", "err during flag ignored", n_inc, 1);
    bits(3, 0);
    chk("R6", "superposed dominant recessive tx", last_tx, 1);
    cur_req = "R5";
    bits(8, 1);
    chk("R5", "no ready after delimiter", n_rdy, 0);
    cur_req = "R10";
    bits(2, 1);
    chk("R10", "no ready before bit 3", n_rdy, 0);
    bit_t(1, 0, 0, 0);
    chk("R10", "ready after bit 3", n_rdy, 1);

    // R4: error in intermission, no discard
    cur_req = "R4";
    clr_cnt();
    bit_t(1, 0, 1, 0);
    bit_t(1, 1, 0, 0);
    chk("R4", "inc in intermission", n_inc, 1);
    chk("R4", "no discard in intermission", n_disc, 0);
    bits(6, 0);
    bits(11, 1);
    chk("R4", "ready after recovery", n_rdy, 1);

    // R3: passive flag
    cur_req = "R3";
    clr_cnt();
    pas = 1;
    bit_t(1, 1, 0, 0);
    bit_t(1, 0, 0, 0); bit_t(1, 0, 0, 0); bit_t(0, 0, 0, 0);
    bits(6, 1);
    chk("R3", "passive flag recessive", dom, 0);
    bits(10, 1);
    chk("R3", "passive run end timing", n_rdy, 0);
    bit_t(1, 0, 0, 0);
    chk("R3", "ready after passive frame", n_rdy, 1);
    pas = 0;

    // R9: dominant at delimiter bit 8
    cur_req = "R9";
    bit_t(1, 1, 0, 0);
    bits(6, 0);
    bits(7, 1);
    clr_cnt();
    bit_t(0, 0, 0, 0);
    chk("R9", "overload starts", last_tx, 0);
    bits(6, 0);
    chk("R9", "overload flag length", dom, 6);
    chk("R9", "no err inc", n_inc, 0);
    bits(11, 1);
    chk("R9", "ready after overload", n_rdy, 1);

    // R8: dominant at intermission bit 2
    cur_req = "R8";
    bit_t(1, 0, 1, 0);
    bit_t(1, 0, 0, 0);
    clr_cnt();
    bit_t(0, 0, 0, 0);
    chk("R8", "overload at bit 2", last_tx, 0);
    bits(6, 0);
    chk("R8", "overload length", dom, 6);
    chk("R8", "no err inc", n_inc, 0);
    bits(11, 1);

    // R10: dominant at bit 3 ends intermission
    cur_req = "R10";
    clr_cnt();
    bit_t(1, 0, 1, 0);
    bits(2, 1);
    bit_t(0, 0, 0, 0);
    chk("R10", "bit3 dominant ready", n_rdy, 1);
    chk("R10", "bit3 dominant no overload", dom, 0);

    // R7: internal overload request
    cur_req = "R7";
    clr_cnt();
    bit_t(1, 0, 0, 1);
    bit_t(1, 0, 1, 0);
    chk("R7", "flag on first intermission bit", last_tx, 0);
    bits(6, 0);
    bits(11, 1);
    chk("R7", "ready after internal overload", n_rdy, 1);
    clr_cnt();
    bit_t(1, 0, 1, 0);
    bit_t(1, 0, 0, 1);
    bits(2, 1);
    chk("R7", "mid-intermission request deferred", dom, 0);
    chk("R7", "intermission completes", n_rdy, 1);
    bit_t(1, 0, 1, 0);
    chk("R7", "held request at next intermission", last_tx, 0);
    bits(6, 0);
    bits(11, 1);
    chk("R7", "final ready", n_rdy, 2);

    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule